// File: doc/BRIEF.md
# Shared Cache Event Counter Monitor

This block watches the traffic of a shared last-level cache and keeps a bank of up to sixteen 48-bit event counters. Every cycle the cache side presents one event: a valid strobe, an 8-bit event code and the index of the core that made the request. A counter advances when three things hold. Its enable bit is set, the event code equals the code chosen for it, and the requesting core's bit is set in that counter's 16-bit core filter.

Software works the block through a 64-bit register window. The window holds the counters, a control word, two packed event-code words, four packed core-filter words and an overflow status word. A second, narrow register port holds the set of cores that receive the overflow interrupt. Bit 47 of a counter is its overflow marker. When an increment sets that bit, a sticky status flag rises. If that counter's interrupt is enabled and the interrupt mode is not off, the interrupt vector output drives the interrupt target mask.

A service routine disables the counters that overflowed, rewrites them and clears the status. It then enables them again. A version parameter chosen at elaboration moves the control and status fields between two layouts. Version 1 is intended for eight or fewer counters.

Top module: `llc_evmon`

## Requirements
- R1: After reset, every counter, event code, core filter, control field, status flag and the interrupt target mask read 0, and the interrupt vector is 0.
- R2: Counter n is read and written at 0x4100 + 8·n when n is even, and at 0x4248 + 4·(n−1) when n is odd. A write loads bits 47:0 on the next edge, whether or not the counter is enabled.
- R3: A counter increments by one on a cycle where the event is valid, its enable bit is 1, the event code equals its selected code and its core-filter bit at the event's core index is 1. Otherwise it holds.
- R4: Event codes are 8 bits per counter. Counter c sits in byte c mod 8 of the word at 0x41B0 (counters 0–7) or 0x41B8 (counters 8–15).
- R5: Core filters are 16 bits per counter. Counter c sits in bits 16·(c mod 4) upward of the word at 0x4190 + 8·(c div 4).
- R6: The control word at 0x4180 holds the enables in bits N−1:0. In version 2 the 3-bit interrupt mode sits at bit 16 and the per-counter interrupt enables start at bit 20. In version 1 these are bit 8 and bit 12. Other bits read 0.
- R7: An increment that takes bit 47 from 0 to 1 sets that counter's flag in the status word at 0x41C0. The flag sits at bit 2+c in version 2 and at bit 1+c in version 1. In version 2 the same event also sets bit 1, the cross-trigger flag.
- R8: A status write loads the flags from the written bits, so writing 0 clears them all. A flag set by an overflow in the same cycle stays set.
- R9: The interrupt vector equals the interrupt target mask when some flag has its interrupt enable set and the mode field is not 0. Otherwise it is 0.
- R10: The interrupt target mask is written and read on the second port at offset 0x1010. Any other offset on that port reads 0.
- R11: A counter write in the same cycle as a qualifying event loads the written value, and it sets no flag.
- R12: A counter at all ones that increments wraps to 0 and sets no flag.
- R13: Unmapped offsets on the main port read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| regWrEn | input | 1 | Main port write strobe |
| regAddr | input | 16 | Main port offset (read and write) |
| regWrData | input | 64 | Main port write data |
| regRdData | output | 64 | Main port read data, combinational from regAddr |
| irqWrEn | input | 1 | Second port write strobe |
| irqAddr | input | 16 | Second port offset |
| irqWrData | input | CORE_W | Second port write data |
| irqRdData | output | CORE_W | Second port read data |
| evtValid | input | 1 | Event present this cycle |
| evtId | input | 8 | Event code |
| evtCore | input | log2(CORE_W) | Index of the requesting core |
| irqVec | output | CORE_W | Per-core overflow interrupt |

## Verification
The bench targets the cycle where a software write and a counting event land together. In one case a rewrite must beat the increment, or the counter ends one too high with a spurious flag. In the other a status clear must not erase an overflow arriving that same cycle, or the interrupt is lost. It also probes the interleaved even/odd counter offsets, where a decode slip makes one counter alias another. It checks that a counter already past bit 47 wraps without raising a flag again. Filtering is tested with a matching code from a masked core and with a disabled counter, either of which would otherwise count silently. A separate version-1 instance confirms the shifted control and status fields, which a hard-wired layout would misplace.

// File: rtl/llc_evmon_pkg.sv
package llc_evmon_pkg;

  localparam int MAX_CTRS  = 16;
  localparam int SEL_REGS  = 2;
  localparam int MASK_REGS = 4;
  localparam int EVT_W     = 8;
  localparam int SLOT_W    = 16;

  localparam logic [15:0] OFS_CTRL    = 16'h4180;
  localparam logic [15:0] OFS_MASK0   = 16'h4190;
  localparam logic [15:0] OFS_SEL0    = 16'h41B0;
  localparam logic [15:0] OFS_STAT    = 16'h41C0;
  localparam logic [15:0] OFS_IRQMASK = 16'h1010;

  typedef enum logic [2:0] {
    RD_NONE, RD_CTRL, RD_STAT, RD_SEL, RD_MASK, RD_CTR
  } rdKind_e;

  typedef struct packed {
    logic                 ctrlWr;
    logic                 statWr;
    logic [SEL_REGS-1:0]  selWr;
    logic [MASK_REGS-1:0] maskWr;
    logic [MAX_CTRS-1:0]  ctrWr;
    logic                 irqMaskWr;
    logic                 irqRdHit;
    rdKind_e              rdKind;
    logic [3:0]           rdIdx;
  } strobe_t;

  // Interleaved counter placement: even counters in one run, odd in another.
  function automatic logic [15:0] ctrOffset(input int n);
    if ((n % 2) == 0) return 16'h4100 + 16'(8 * n);
    else              return 16'h4248 + 16'(4 * (n - 1));
  endfunction

endpackage

// File: rtl/llc_evmon_decode.sv
module llc_evmon_decode
  import llc_evmon_pkg::*;
#(
  parameter int NUM_CTRS = 16
) (
  input  logic        regWrEn,
  input  logic [15:0] regAddr,
  input  logic        irqWrEn,
  input  logic [15:0] irqAddr,
  output strobe_t     strb
);

  always_comb begin
    strb = '0;
    if (regAddr == OFS_CTRL) begin
      strb.rdKind = RD_CTRL;
      strb.ctrlWr = regWrEn;
    end
    if (regAddr == OFS_STAT) begin
      strb.rdKind = RD_STAT;
      strb.statWr = regWrEn;
    end
    for (int r = 0; r < SEL_REGS; r++) begin
      if (regAddr == OFS_SEL0 + 16'(8 * r)) begin
        strb.rdKind   = RD_SEL;
        strb.rdIdx    = 4'(r);
        strb.selWr[r] = regWrEn;
      end
    end
    for (int r = 0; r < MASK_REGS; r++) begin
      if (regAddr == OFS_MASK0 + 16'(8 * r)) begin
        strb.rdKind    = RD_MASK;
        strb.rdIdx     = 4'(r);
        strb.maskWr[r] = regWrEn;
      end
    end
    for (int i = 0; i < NUM_CTRS; i++) begin
      if (regAddr == ctrOffset(i)) begin
        strb.rdKind   = RD_CTR;
        strb.rdIdx    = 4'(i);
        strb.ctrWr[i] = regWrEn;
      end
    end
    strb.irqRdHit  = (irqAddr == OFS_IRQMASK);
    strb.irqMaskWr = irqWrEn && (irqAddr == OFS_IRQMASK);
  end

endmodule

// File: rtl/llc_evmon_core.sv
module llc_evmon_core
  import llc_evmon_pkg::*;
#(
  parameter int NUM_CTRS  = 16,
  parameter int CTR_W     = 48,
  parameter int CORE_W    = 16,
  parameter int VERSION   = 2,
  parameter int CORE_ID_W = $clog2(CORE_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  strobe_t              strb,
  input  logic [63:0]          regWrData,
  input  logic [CORE_W-1:0]    irqWrData,
  input  logic                 evtValid,
  input  logic [EVT_W-1:0]     evtId,
  input  logic [CORE_ID_W-1:0] evtCore,
  output logic [63:0]          regRdData,
  output logic [CORE_W-1:0]    irqRdData,
  output logic [CORE_W-1:0]    irqVec
);

  localparam int GEN_LSB = (VERSION == 1) ? 8  : 16;
  localparam int IE_LSB  = (VERSION == 1) ? 12 : 20;
  localparam int OVF_LSB = (VERSION == 1) ? 1  : 2;
  localparam int SEL_PER = 8;
  localparam int MSK_PER = 4;

  logic [NUM_CTRS-1:0] enMask;
  logic [NUM_CTRS-1:0] intEn;
  logic [2:0]          genMode;
  logic [CORE_W-1:0]   irqMask;
  logic                xTrig;
  logic [NUM_CTRS-1:0] ovfFlag;
  logic [NUM_CTRS-1:0] ovfSet;
  logic [CTR_W-1:0]    ctrVal  [NUM_CTRS];
  logic [EVT_W-1:0]    selArr  [NUM_CTRS];
  logic [CORE_W-1:0]   maskArr [NUM_CTRS];

  // Global configuration
  always_ff @(posedge clk) begin
    if (rst) begin
      enMask  <= '0;
      intEn   <= '0;
      genMode <= '0;
      irqMask <= '0;
      xTrig   <= 1'b0;
    end else begin
      if (strb.ctrlWr) begin
        enMask  <= regWrData[NUM_CTRS-1:0];
        genMode <= regWrData[GEN_LSB +: 3];
        intEn   <= regWrData[IE_LSB +: NUM_CTRS];
      end
      if (strb.irqMaskWr) irqMask <= irqWrData;
      if (VERSION == 2) begin
        if (strb.statWr) xTrig <= regWrData[1] | (|ovfSet);
        else             xTrig <= xTrig | (|ovfSet);
      end
    end
  end

  // One slice per counter: selector, core filter, count and sticky flag
  for (genvar c = 0; c < NUM_CTRS; c++) begin : g_ctr
    logic [EVT_W-1:0]  sel;
    logic [CORE_W-1:0] cmask;
    logic [CTR_W-1:0]  val;
    logic [CTR_W-1:0]  nxt;
    logic              flag;
    logic              hit;
    logic              setOvf;

    assign hit    = enMask[c] & evtValid & (sel == evtId) & cmask[evtCore];
    assign nxt    = val + CTR_W'(1);
    assign setOvf = hit & ~strb.ctrWr[c] & ~val[CTR_W-1] & nxt[CTR_W-1];

    always_ff @(posedge clk) begin
      if (rst) begin
        sel   <= '0;
        cmask <= '0;
        val   <= '0;
        flag  <= 1'b0;
      end else begin
        if (strb.selWr[c / SEL_PER])  sel   <= regWrData[EVT_W*(c % SEL_PER) +: EVT_W];
        if (strb.maskWr[c / MSK_PER]) cmask <= regWrData[SLOT_W*(c % MSK_PER) +: CORE_W];
        if (strb.ctrWr[c])            val   <= regWrData[CTR_W-1:0];
        else if (hit)                 val   <= nxt;
        if (strb.statWr) flag <= regWrData[OVF_LSB + c] | setOvf;
        else             flag <= flag | setOvf;
      end
    end

    assign ovfSet[c]  = setOvf;
    assign ovfFlag[c] = flag;
    assign ctrVal[c]  = val;
    assign selArr[c]  = sel;
    assign maskArr[c] = cmask;
  end

  // Read mux
  always_comb begin
    regRdData = '0;
    case (strb.rdKind)
      RD_CTRL: begin
        regRdData[NUM_CTRS-1:0]         = enMask;
        regRdData[GEN_LSB +: 3]         = genMode;
        regRdData[IE_LSB +: NUM_CTRS]   = intEn;
      end
      RD_STAT: begin
        regRdData[OVF_LSB +: NUM_CTRS]  = ovfFlag;
        if (VERSION == 2) regRdData[1]  = xTrig;
      end
      RD_SEL: begin
        for (int c = 0; c < NUM_CTRS; c++)
          if ((c / SEL_PER) == int'(strb.rdIdx))
            regRdData[EVT_W*(c % SEL_PER) +: EVT_W] = selArr[c];
      end
      RD_MASK: begin
        for (int c = 0; c < NUM_CTRS; c++)
          if ((c / MSK_PER) == int'(strb.rdIdx))
            regRdData[SLOT_W*(c % MSK_PER) +: CORE_W] = maskArr[c];
      end
      RD_CTR: begin
        for (int c = 0; c < NUM_CTRS; c++)
          if (c == int'(strb.rdIdx)) regRdData[CTR_W-1:0] = ctrVal[c];
      end
      default: regRdData = '0;
    endcase
  end

  assign irqRdData = strb.irqRdHit ? irqMask : '0;
  assign irqVec    = ((|(ovfFlag & intEn)) && (genMode != 3'd0)) ? irqMask : '0;

endmodule

// File: rtl/llc_evmon.sv
module llc_evmon
  import llc_evmon_pkg::*;
#(
  parameter int NUM_CTRS  = 16,
  parameter int CTR_W     = 48,
  parameter int CORE_W    = 16,
  parameter int VERSION   = 2,
  parameter int CORE_ID_W = $clog2(CORE_W)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 regWrEn,
  input  logic [15:0]          regAddr,
  input  logic [63:0]          regWrData,
  output logic [63:0]          regRdData,
  input  logic                 irqWrEn,
  input  logic [15:0]          irqAddr,
  input  logic [CORE_W-1:0]    irqWrData,
  output logic [CORE_W-1:0]    irqRdData,
  input  logic                 evtValid,
  input  logic [EVT_W-1:0]     evtId,
  input  logic [CORE_ID_W-1:0] evtCore,
  output logic [CORE_W-1:0]    irqVec
);

  strobe_t strb;

  llc_evmon_decode #(.NUM_CTRS(NUM_CTRS)) u_decode (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .irqWrEn (irqWrEn),
    .irqAddr (irqAddr),
    .strb    (strb)
  );

  llc_evmon_core #(
    .NUM_CTRS (NUM_CTRS),
    .CTR_W    (CTR_W),
    .CORE_W   (CORE_W),
    .VERSION  (VERSION),
    .CORE_ID_W(CORE_ID_W)
  ) u_core (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .regWrData (regWrData),
    .irqWrData (irqWrData),
    .evtValid  (evtValid),
    .evtId     (evtId),
    .evtCore   (evtCore),
    .regRdData (regRdData),
    .irqRdData (irqRdData),
    .irqVec    (irqVec)
  );

endmodule

// File: rtl/llc_evmon_chk.sv
module llc_evmon_chk
  import llc_evmon_pkg::*;
#(
  parameter int CORE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              regWrEn,
  input logic [15:0]       regAddr,
  input logic [63:0]       regWrData,
  input logic              evtValid,
  input logic              irqWrEn,
  input logic [15:0]       irqAddr,
  input logic [CORE_W-1:0] irqRdData,
  input logic [CORE_W-1:0] irqVec,
  input strobe_t           strb
);

  assert_irq_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irqVec == '0));

  assert_one_write_target_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.ctrlWr, strb.statWr, strb.selWr, strb.maskWr, strb.ctrWr}));

  assert_clear_drops_irq_R8: assert property (@(posedge clk) disable iff (rst)
    (regWrEn && regAddr == OFS_STAT && regWrData == 64'd0 && !evtValid && !irqWrEn)
      |=> (irqVec == '0));

  assert_irq_within_mask_R9: assert property (@(posedge clk) disable iff (rst)
    (irqVec != '0 && irqAddr == OFS_IRQMASK) |-> (irqVec == irqRdData));

  assert_no_change_when_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (!evtValid && !regWrEn && !irqWrEn) |=> $stable(irqVec));

endmodule

bind llc_evmon llc_evmon_chk #(.CORE_W(CORE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .regWrEn   (regWrEn),
  .regAddr   (regAddr),
  .regWrData (regWrData),
  .evtValid  (evtValid),
  .irqWrEn   (irqWrEn),
  .irqAddr   (irqAddr),
  .irqRdData (irqRdData),
  .irqVec    (irqVec),
  .strb      (strb)
);

// File: tb/llc_evmon_tb.sv
module llc_evmon_tb;

  localparam logic [63:0] M48 = 64'h0000_FFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        regWrEn = 1'b0;
  logic [15:0] regAddr = 16'h0;
  logic [63:0] regWrData = 64'h0;
  logic [63:0] regRdData;
  logic        irqWrEn = 1'b0;
  logic [15:0] irqAddr = 16'h0;
  logic [15:0] irqWrData = 16'h0;
  logic [15:0] irqRdData;
  logic        evtValid = 1'b0;
  logic [7:0]  evtId = 8'h0;
  logic [3:0]  evtCore = 4'h0;
  logic [15:0] irqVec;

  // version-1 instance
  logic        w1En = 1'b0;
  logic [15:0] a1 = 16'h0;
  logic [63:0] d1 = 64'h0;
  logic [63:0] rd1;
  logic        i1En = 1'b0;
  logic [15:0] i1Data = 16'h0;
  logic [15:0] i1Rd;
  logic        e1V = 1'b0;
  logic [15:0] vec1;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  running = 1'b0;
  bit  finished = 1'b0;

  always #2 clk = ~clk;

  llc_evmon u_dut (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .irqWrEn(irqWrEn), .irqAddr(irqAddr), .irqWrData(irqWrData),
    .irqRdData(irqRdData), .evtValid(evtValid), .evtId(evtId), .evtCore(evtCore),
    .irqVec(irqVec)
  );

  llc_evmon #(.NUM_CTRS(8), .VERSION(1)) u_dutV1 (
    .clk(clk), .rst(rst), .regWrEn(w1En), .regAddr(a1), .regWrData(d1),
    .regRdData(rd1), .irqWrEn(i1En), .irqAddr(16'h1010), .irqWrData(i1Data),
    .irqRdData(i1Rd), .evtValid(e1V), .evtId(8'h00), .evtCore(4'h0),
    .irqVec(vec1)
  );

  // ---------------- behavioural reference model (version 2, 16 counters)
  longint unsigned mCtr [16];
  logic [7:0]      mSel [16];
  logic [15:0]     mMsk [16];
  logic [15:0]     mEn, mIe, mOvf, mImask, mSet, mWr;
  logic [2:0]      mGen;
  logic            mXt;
  longint unsigned nv;

  function automatic int ctrIndex(input logic [15:0] a);
    for (int n = 0; n < 16; n++) begin
      if (n % 2 == 0 && a == 16'h4100 + 16'(8 * n)) return n;
      if (n % 2 == 1 && a == 16'h4248 + 16'(4 * (n - 1))) return n;
    end
    return -1;
  endfunction

  function automatic logic [63:0] modelRead(input logic [15:0] a);
    logic [63:0] v;
    int k;
    v = 64'h0;
    k = ctrIndex(a);
    if (k >= 0) v = mCtr[k];
    else if (a == 16'h4180) v = {28'h0, mIe, 1'b0, mGen, mEn};
    else if (a == 16'h41C0) v = {46'h0, mOvf, mXt, 1'b0};
    else if (a == 16'h41B0 || a == 16'h41B8) begin
      for (int j = 0; j < 8; j++) v[8*j +: 8] = mSel[(a == 16'h41B8 ? 8 : 0) + j];
    end else begin
      for (int r = 0; r < 4; r++)
        if (a == 16'h4190 + 16'(8 * r))
          for (int j = 0; j < 4; j++) v[16*j +: 16] = mMsk[4*r + j];
    end
    return v;
  endfunction

  function automatic string tagOf(input logic [15:0] a);
    if (ctrIndex(a) >= 0) return "R2/R3";
    if (a == 16'h4180) return "R6";
    if (a == 16'h41C0) return "R7/R8";
    if (a == 16'h41B0 || a == 16'h41B8) return "R4";
    if (a >= 16'h4190 && a <= 16'h41A8) return "R5";
    return "R13";
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 16; i++) begin
        mCtr[i] = 0; mSel[i] = 0; mMsk[i] = 0;
      end
      mEn = 0; mIe = 0; mOvf = 0; mImask = 0; mGen = 0; mXt = 0;
    end else begin
      mSet = 0; mWr = 0;
      if (regWrEn && ctrIndex(regAddr) >= 0) mWr[ctrIndex(regAddr)] = 1'b1;
      for (int i = 0; i < 16; i++) begin
        if (mWr[i]) mCtr[i] = regWrData & M48;
        else if (evtValid && mEn[i] && mSel[i] == evtId && mMsk[i][evtCore]) begin
          nv = (mCtr[i] + 1) & M48;
          if (mCtr[i][47] == 1'b0 && nv[47] == 1'b1) mSet[i] = 1'b1;
          mCtr[i] = nv;
        end
      end
      if (regWrEn) begin
        if (regAddr == 16'h4180) begin
          mEn = regWrData[15:0]; mGen = regWrData[18:16]; mIe = regWrData[35:20];
        end
        if (regAddr == 16'h41C0) begin
          mOvf = regWrData[17:2]; mXt = regWrData[1];
        end
        if (regAddr == 16'h41B0) for (int j = 0; j < 8; j++) mSel[j]     = regWrData[8*j +: 8];
        if (regAddr == 16'h41B8) for (int j = 0; j < 8; j++) mSel[8 + j] = regWrData[8*j +: 8];
        for (int r = 0; r < 4; r++)
          if (regAddr == 16'h4190 + 16'(8 * r))
            for (int j = 0; j < 4; j++) mMsk[4*r + j] = regWrData[16*j +: 16];
      end
      mOvf = mOvf | mSet;
      if (mSet != 0) mXt = 1'b1;
      if (irqWrEn && irqAddr == 16'h1010) mImask = irqWrData;
    end
  end

  // ---------------- checking
  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (running && !rst) begin
      check(tagOf(regAddr), regRdData, modelRead(regAddr));
      check("R10", {48'h0, irqRdData}, (irqAddr == 16'h1010) ? {48'h0, mImask} : 64'h0);
      check("R9", {48'h0, irqVec},
            ((mOvf & mIe) != 0 && mGen != 0) ? {48'h0, mImask} : 64'h0);
    end
  end

  // ---------------- stimulus helpers
  task automatic cyc(input logic wr, input logic [15:0] a, input logic [63:0] d,
                     input logic ev, input logic [7:0] id, input logic [3:0] core);
    @(posedge clk); #1;
    regWrEn = wr; regAddr = a; regWrData = d;
    evtValid = ev; evtId = id; evtCore = core;
    irqWrEn = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [63:0] d);
    cyc(1'b1, a, d, 1'b0, 8'h0, 4'h0);
  endtask

  task automatic evt(input logic [7:0] id, input logic [3:0] core, input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0, 64'h0, 1'b1, id, core);
  endtask

  task automatic rdChk(input logic [15:0] a, input logic [63:0] exp, input string tag);
    cyc(1'b0, a, 64'h0, 1'b0, 8'h0, 4'h0);
    @(negedge clk);
    check(tag, regRdData, exp);
  endtask

  task automatic irqChk(input logic [15:0] exp, input string tag);
    @(negedge clk);
    check(tag, {48'h0, irqVec}, {48'h0, exp});
  endtask

  task automatic cyc1(input logic w, input logic [15:0] a, input logic [63:0] d,
                      input logic ev, input logic iw, input logic [15:0] idata);
    @(posedge clk); #1;
    w1En = w; a1 = a; d1 = d; e1V = ev; i1En = iw; i1Data = idata;
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    running = 1'b1;

    // R1 reset state
    rdChk(16'h4180, 64'h0, "R1");
    rdChk(16'h41C0, 64'h0, "R1");
    rdChk(16'h4280, 64'h0, "R1");
    irqChk(16'h0, "R1");

    // R10 second port
    @(posedge clk); #1;
    regWrEn = 0; evtValid = 0; irqWrEn = 1'b1; irqAddr = 16'h1010; irqWrData = 16'hA5A5;
    @(posedge clk); #1 irqWrEn = 1'b0;
    @(negedge clk); check("R10", {48'h0, irqRdData}, 64'hA5A5);
    @(posedge clk); #1 irqAddr = 16'h1018;
    @(negedge clk); check("R10", {48'h0, irqRdData}, 64'h0);
    @(posedge clk); #1 irqAddr = 16'h1010;

    // R4 / R5 packing
    wr(16'h41B0, 64'h1716_1514_1312_1110);
    rdChk(16'h41B0, 64'h1716_1514_1312_1110, "R4");
    wr(16'h41B8, 64'h2F2E_2D2C_2B2A_2928);
    rdChk(16'h41B8, 64'h2F2E_2D2C_2B2A_2928, "R4");
    wr(16'h4190, 64'h0000_FFFF_FFFF_0004);
    rdChk(16'h4190, 64'h0000_FFFF_FFFF_0004, "R5");
    wr(16'h41A8, 64'h1234_5678_9ABC_DEF0);
    rdChk(16'h41A8, 64'h1234_5678_9ABC_DEF0, "R5");

    // R6 control layout
    wr(16'h4180, 64'hFFFF_FFF0_0034_0003);
    rdChk(16'h4180, 64'h0000_0000_0034_0003, "R6");

    // R3 qualified counting
    evt(8'h10, 4'd2, 3);
    evt(8'h10, 4'd3, 2);
    evt(8'h11, 4'd5, 4);
    evt(8'h12, 4'd0, 2);
    rdChk(16'h4100, 64'd3, "R3");
    rdChk(16'h4248, 64'd4, "R3");
    rdChk(16'h4110, 64'd0, "R3");

    // R2 odd counter written while disabled
    wr(16'h4250, 64'hFFFF_1234_5678_9ABC);
    rdChk(16'h4250, 64'h0000_1234_5678_9ABC, "R2");
    rdChk(16'h4108, 64'h0, "R2");

    // R7 / R9 overflow and interrupt
    wr(16'h4100, 64'h0000_7FFF_FFFF_FFFF);
    evt(8'h10, 4'd2, 1);
    rdChk(16'h4100, 64'h0000_8000_0000_0000, "R7");
    rdChk(16'h41C0, 64'h6, "R7");
    irqChk(16'hA5A5, "R9");
    wr(16'h4180, 64'h0000_0000_0030_0003);
    rdChk(16'h4180, 64'h0000_0000_0030_0003, "R6");
    irqChk(16'h0, "R9");
    wr(16'h4180, 64'h0000_0000_0034_0003);
    rdChk(16'h4180, 64'h0000_0000_0034_0003, "R6");
    irqChk(16'hA5A5, "R9");

    // R8 clear, and overflow racing a clear
    wr(16'h41C0, 64'h0);
    rdChk(16'h41C0, 64'h0, "R8");
    irqChk(16'h0, "R8");
    wr(16'h4248, 64'h0000_7FFF_FFFF_FFFF);
    cyc(1'b1, 16'h41C0, 64'h0, 1'b1, 8'h11, 4'd0);
    rdChk(16'h41C0, 64'hA, "R8");
    irqChk(16'hA5A5, "R8");
    wr(16'h41C0, 64'h0);

    // R11 write beats increment
    cyc(1'b1, 16'h4100, 64'h0000_7FFF_FFFF_FFFF, 1'b1, 8'h10, 4'd2);
    rdChk(16'h4100, 64'h0000_7FFF_FFFF_FFFF, "R11");
    rdChk(16'h41C0, 64'h0, "R11");

    // R12 wrap at all ones
    wr(16'h4100, 64'h0000_FFFF_FFFF_FFFF);
    evt(8'h10, 4'd2, 1);
    rdChk(16'h4100, 64'h0, "R12");
    rdChk(16'h41C0, 64'h0, "R12");
    irqChk(16'h0, "R12");

    // R13 unmapped offsets
    rdChk(16'h4178, 64'h0, "R13");
    wr(16'h4178, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(16'h41C8, 64'hFFFF_FFFF_FFFF_FFFF);
    rdChk(16'h4180, 64'h0000_0000_0034_0003, "R13");
    rdChk(16'h4100, 64'h0, "R13");
    rdChk(16'h41C0, 64'h0, "R13");

    // R6 / R7 / R9 version-1 layout
    cyc1(1'b1, 16'h4180, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 16'h0);
    cyc1(1'b0, 16'h4180, 64'h0, 1'b0, 1'b0, 16'h0);
    @(negedge clk); check("R6 v1", rd1, 64'h0000_0000_000F_F7FF);
    cyc1(1'b1, 16'h4190, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 16'h0);
    cyc1(1'b1, 16'h4100, 64'h0000_7FFF_FFFF_FFFF, 1'b0, 1'b1, 16'h0001);
    cyc1(1'b0, 16'h41C0, 64'h0, 1'b1, 1'b0, 16'h0);
    cyc1(1'b0, 16'h41C0, 64'h0, 1'b0, 1'b0, 16'h0);
    @(negedge clk);
    check("R7 v1", rd1, 64'h2);
    check("R9 v1", {48'h0, vec1}, 64'h1);
    cyc1(1'b0, 16'h4248, 64'h0, 1'b0, 1'b0, 16'h0);
    @(negedge clk); check("R3 v1", rd1, 64'h1);

    repeat (2) @(posedge clk);
    running = 1'b0;
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule